// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits behind the asynchronous bus of a parallel NOR flash and turns runs of bus writes into program and erase operations on a small register-based storage model. Every bus input is sampled on the system clock. A write pulse is the interval in which chip enable and write enable are both low. The block records the address when the second of the two strobes falls, and it records the data when the first of the two rises. It then compares the cycle with the command grammar it expects next. A run of cycles that breaks the grammar drops the block back to plain reading.

A program or erase that has been accepted drives the ready/busy line low for a fixed number of clock cycles, set by a parameter. During that time every read returns a status byte: bit 7 is the complement of written bit 7, bit 6 flips on each new read, and bit 5 reports a program that tried to raise a cleared bit. A sector erase can be suspended. While it is suspended, other sectors can be read and programmed, and the erase can then be resumed. An identification mode returns a maker code and a device code. A byte/word select changes the unlock addresses and the width of each access.

Top module: `fl_cmd_ctrl`

## Requirements
- R1: After rst_n is deasserted, ry_by is 1 and rdata is 0 while no read is active. Pulling rst_n low while a program is busy abandons the program: ry_by returns to 1 and the target word keeps its previous value.
- R2: The block records the address on the clock edge where chip enable and write enable are first both low, which is the later of the two falling strobes. It records the data on the edge where the first strobe rises. An address change between those two edges has no effect.
- R3: The unlock cycles are AAh followed by 55h. In word mode (byte_mode=0) their addresses are 555h and then 2AAh, compared on address bits 10:0. In byte mode (byte_mode=1) they are AAAh and then 555h, compared on bits 11:0. Higher address bits are ignored.
- R4: A cycle whose address or data does not match the expected next step ends the sequence and returns to read mode. A data write made after that point changes nothing.
- R5: Commands are decoded from wdata[7:0] only. The value of wdata[15:8] has no effect on command cycles.
- R6: Program is unlock, unlock, A0h at the first unlock address, then the data cycle. The stored word becomes old AND new. ry_by is low for exactly PGM_CYC cycles. After that, a read returns the stored word.
- R7: While busy, a read returns {8'h00, dq7, dq6, dq5, 5'b0}. For a program, dq7 is the complement of written bit 7. dq6 inverts on every new read.
- R8: A program that tries to change a 0 bit to 1 ends in a fault. Reads then show dq5=1 and ry_by is 1. Only a single F0h write, at any address, returns to read mode.
- R9: Unlock, unlock, then 90h at the first unlock address enters identification. Reads at word index 0 return MFR_CODE, at index 1 DEV_CODE, and at index 2 zero. In byte mode each read returns the low byte, taken from byte address 0 or 2. Any write leaves identification.
- R10: Unlock, unlock, 80h, unlock, unlock, then 10h at the first unlock address erases every word to FFFFh. ry_by is low for exactly ERS_CYC cycles.
- R11: If the sixth erase cycle is 30h, only the sector that holds the word at that cycle's address is set to FFFFh.
- R12: B0h during a sector erase suspends it: ry_by rises and the erase count holds. While suspended, reads and programs to other sectors work, and a program to the suspended sector is ignored. A 30h write resumes the erase. B0h during a chip erase is ignored.
- R13: In byte mode, the word index is address bits IDX_W:1, and address bit 0 selects the high byte. A byte program changes only that byte, and a byte read returns it in rdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset of the controller |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 selects byte access, 0 selects word access |
| addr | input | ADDR_W | Bus address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data or status; 0 when no read is active |
| ry_by | output | 1 | 1 = ready, 0 = program or erase running |

## Verification
A command takes effect on the first clock edge after the write pulse ends. The bench therefore releases the strobes at a falling edge and waits one more falling edge before its next action. A read becomes valid one edge after the strobes go low, because the status toggle advances on that edge, so each read is sampled at the next falling edge. Busy lengths are measured with a counter of falling edges at which ry_by is low, cleared before the command and compared against PGM_CYC or ERS_CYC exactly. The two status reads in each program window are placed so that both land before the last busy cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_IDENT, ST_PSET, ST_EU0, ST_EU1, ST_EU2,
    ST_PBUSY, ST_EBUSY, ST_ESUSP, ST_FAULT
  } fl_state_e;

  localparam logic [7:0] C_UNLK_A  = 8'hAA;
  localparam logic [7:0] C_UNLK_B  = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERSETUP = 8'h80;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECT    = 8'h30;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_RESET   = 8'hF0;

  // First unlock address; upper bits are don't-care
  function automatic logic at_first(input logic [11:0] a, input logic bm);
    return bm ? (a == 12'hAAA) : (a[10:0] == 11'h555);
  endfunction

  function automatic logic at_second(input logic [11:0] a, input logic bm);
    return bm ? (a == 12'h555) : (a[10:0] == 11'h2AA);
  endfunction

  // Bits a program cycle may touch
  function automatic logic [15:0] lane_mask(input logic bm, input logic hi);
    return bm ? (hi ? 16'hFF00 : 16'h00FF) : 16'hFFFF;
  endfunction

  // Programmed value placed on its lane, ones elsewhere
  function automatic logic [15:0] lane_value(input logic [15:0] d, input logic bm, input logic hi);
    return bm ? (hi ? {d[7:0], 8'hFF} : {8'hFF, d[7:0]}) : d;
  endfunction
endpackage

// File: rtl/fl_bus_sample.sv
module fl_bus_sample #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_end,
  output logic              rd_start,
  output logic              rd_act,
  output logic [ADDR_W-1:0] wr_addr
);
  logic wr_act, wr_q, rd_q;

  assign wr_act   = ~ce_n & ~we_n;
  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign wr_end   = wr_q & ~wr_act;
  assign rd_start = rd_act & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) wr_addr <= addr;
    end
  end
endmodule

// File: rtl/fl_array.sv
module fl_array #(
  parameter int WORDS  = 32,
  parameter int IDX_W  = 5,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              pgm_go,
  input  logic [IDX_W-1:0]  pgm_idx,
  input  logic [15:0]       pgm_word,
  input  logic              ers_go,
  input  logic              ers_all,
  input  logic [SECT_W-1:0] ers_sect,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [15:0]       rd_word,
  output logic [15:0]       old_word
);
  logic [WORDS-1:0][15:0] cells;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic [15:0] w;
    always_ff @(posedge clk) begin
      if (pgm_go && pgm_idx == MY_IDX)
        w <= pgm_word;
      else if (ers_go && (ers_all || MY_IDX[IDX_W-1 -: SECT_W] == ers_sect))
        w <= 16'hFFFF;
    end
    assign cells[i] = w;
  end

  assign rd_word  = cells[rd_idx];
  assign old_word = cells[pgm_idx];
endmodule

// File: rtl/fl_cmd_fsm.sv
module fl_cmd_fsm
  import fl_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int SECT_W  = 2,
  parameter int PGM_CYC = 8,
  parameter int ERS_CYC = 40,
  parameter int CNT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_end,
  input  logic [11:0]       cmd_addr,
  input  logic [15:0]       wdata,
  input  logic              byte_mode,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic              rd_start,
  input  logic [15:0]       old_word,
  output fl_state_e         st,
  output logic              susp,
  output logic              tog,
  output logic              ry_by,
  output logic              stat_mode,
  output logic              dq7,
  output logic              pgm_go,
  output logic [IDX_W-1:0]  pgm_idx,
  output logic [15:0]       pgm_word,
  output logic              ers_go,
  output logic              ers_all,
  output logic [SECT_W-1:0] ers_sect,
  output logic [CNT_W-1:0]  ecnt
);
  logic [CNT_W-1:0] pcnt;
  logic [15:0] p_val, p_mask;
  logic        p_b7, conflict;
  logic [7:0]  cmd;
  logic        u1, u2, start_pgm, start_ers, start_all, resume;
  fl_state_e   nxt, base;

  assign cmd       = wdata[7:0];
  assign u1        = at_first(cmd_addr, byte_mode);
  assign u2        = at_second(cmd_addr, byte_mode);
  assign base      = susp ? ST_ESUSP : ST_READ;
  assign ry_by     = !(st == ST_PBUSY || st == ST_EBUSY);
  assign stat_mode = (st == ST_PBUSY) || (st == ST_EBUSY) || (st == ST_FAULT);
  assign dq7       = (st == ST_EBUSY) ? 1'b0 : ~p_b7;
  assign pgm_go    = (st == ST_PBUSY) && (pcnt == '0);
  assign ers_go    = (st == ST_EBUSY) && (ecnt == '0);
  assign pgm_word  = old_word & p_val;
  assign conflict  = |(p_val & p_mask & ~old_word);

  always_comb begin
    nxt = st; start_pgm = 1'b0; start_ers = 1'b0; start_all = 1'b0; resume = 1'b0;
    case (st)
      ST_READ:  nxt = (cmd == C_UNLK_A && u1) ? ST_U1 : ST_READ;
      ST_ESUSP: begin
        if (cmd == C_SECT) begin nxt = ST_EBUSY; resume = 1'b1; end
        else if (cmd == C_UNLK_A && u1) nxt = ST_U1;
      end
      ST_U1:    nxt = (cmd == C_UNLK_B && u2) ? ST_U2 : base;
      ST_U2: begin
        if (cmd == C_PROG && u1) nxt = ST_PSET;
        else if (cmd == C_IDENT && u1 && !susp) nxt = ST_IDENT;
        else if (cmd == C_ERSETUP && u1 && !susp) nxt = ST_EU0;
        else nxt = base;
      end
      ST_IDENT: nxt = ST_READ;
      ST_FAULT: nxt = (cmd == C_RESET) ? base : ST_FAULT;
      ST_PSET: begin
        if (susp && wr_idx[IDX_W-1 -: SECT_W] == ers_sect) nxt = base;
        else begin nxt = ST_PBUSY; start_pgm = 1'b1; end
      end
      ST_EU0:   nxt = (cmd == C_UNLK_A && u1) ? ST_EU1 : ST_READ;
      ST_EU1:   nxt = (cmd == C_UNLK_B && u2) ? ST_EU2 : ST_READ;
      ST_EU2: begin
        if (cmd == C_CHIP && u1) begin nxt = ST_EBUSY; start_ers = 1'b1; start_all = 1'b1; end
        else if (cmd == C_SECT) begin nxt = ST_EBUSY; start_ers = 1'b1; end
        else nxt = ST_READ;
      end
      default:  nxt = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_READ; susp <= 1'b0; tog <= 1'b0;
      pcnt <= '0; ecnt <= '0; pgm_idx <= '0;
      p_val <= '1; p_mask <= '0; p_b7 <= 1'b0;
      ers_all <= 1'b0; ers_sect <= '0;
    end else begin
      if (rd_start && stat_mode) tog <= ~tog;
      case (st)
        ST_PBUSY: begin
          if (pcnt == '0) st <= conflict ? ST_FAULT : base;
          else pcnt <= pcnt - 1'b1;
        end
        ST_EBUSY: begin
          if (ecnt == '0) st <= ST_READ;
          else begin
            ecnt <= ecnt - 1'b1;
            if (wr_end && cmd == C_SUSP && !ers_all) begin
              st <= ST_ESUSP; susp <= 1'b1;
            end
          end
        end
        default: if (wr_end) begin
          st <= nxt;
          if (resume) susp <= 1'b0;
          if (start_pgm) begin
            pcnt    <= CNT_W'(PGM_CYC - 1);
            pgm_idx <= wr_idx;
            p_val   <= lane_value(wdata, byte_mode, wr_hi);
            p_mask  <= lane_mask(byte_mode, wr_hi);
            p_b7    <= wdata[7];
          end
          if (start_ers) begin
            ecnt     <= CNT_W'(ERS_CYC - 1);
            ers_all  <= start_all;
            ers_sect <= wr_idx[IDX_W-1 -: SECT_W];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fl_cmd_ctrl.sv
module fl_cmd_ctrl
  import fl_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          NUM_SECT   = 4,
  parameter int          SECT_WORDS = 8,
  parameter int          PGM_CYC    = 8,
  parameter int          ERS_CYC    = 40,
  parameter logic [15:0] MFR_CODE   = 16'h00A7,
  parameter logic [15:0] DEV_CODE   = 16'h2291
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              ry_by
);
  localparam int WORDS  = NUM_SECT * SECT_WORDS;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int MAXC   = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a, input logic bm);
    return bm ? a[IDX_W:1] : a[IDX_W-1:0];
  endfunction

  logic              wr_end, rd_start, rd_act;
  logic [ADDR_W-1:0] wr_addr;
  fl_state_e         st;
  logic              susp, tog, stat_mode, dq7;
  logic              pgm_go, ers_go, ers_all;
  logic [IDX_W-1:0]  pgm_idx, rd_idx;
  logic [15:0]       pgm_word, rd_word, old_word, id_word, arr_word;
  logic [SECT_W-1:0] ers_sect;
  logic [CNT_W-1:0]  ecnt;

  fl_bus_sample #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wr_end(wr_end), .rd_start(rd_start), .rd_act(rd_act), .wr_addr(wr_addr)
  );

  fl_cmd_fsm #(.IDX_W(IDX_W), .SECT_W(SECT_W), .PGM_CYC(PGM_CYC),
               .ERS_CYC(ERS_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .cmd_addr(wr_addr[11:0]),
    .wdata(wdata), .byte_mode(byte_mode), .wr_idx(word_of(wr_addr, byte_mode)),
    .wr_hi(byte_mode & wr_addr[0]), .rd_start(rd_start), .old_word(old_word),
    .st(st), .susp(susp), .tog(tog), .ry_by(ry_by), .stat_mode(stat_mode), .dq7(dq7),
    .pgm_go(pgm_go), .pgm_idx(pgm_idx), .pgm_word(pgm_word), .ers_go(ers_go),
    .ers_all(ers_all), .ers_sect(ers_sect), .ecnt(ecnt)
  );

  assign rd_idx = word_of(addr, byte_mode);

  fl_array #(.WORDS(WORDS), .IDX_W(IDX_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .pgm_go(pgm_go), .pgm_idx(pgm_idx), .pgm_word(pgm_word),
    .ers_go(ers_go), .ers_all(ers_all), .ers_sect(ers_sect),
    .rd_idx(rd_idx), .rd_word(rd_word), .old_word(old_word)
  );

  always_comb begin
    case (rd_idx[1:0])
      2'd0:    id_word = MFR_CODE;
      2'd1:    id_word = DEV_CODE;
      default: id_word = 16'h0000;
    endcase
    arr_word = (st == ST_IDENT) ? id_word : rd_word;
    if (!rd_act)
      rdata = 16'h0000;
    else if (stat_mode)
      rdata = {8'h00, dq7, tog, st == ST_FAULT, 5'b00000};
    else if (byte_mode)
      rdata = {8'h00, (addr[0] && st != ST_IDENT) ? arr_word[15:8] : arr_word[7:0]};
    else
      rdata = arr_word;
  end
endmodule

// File: rtl/fl_cmd_ctrl_chk.sv
module fl_cmd_ctrl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ry_by,
  input logic             rd_start,
  input logic             tog,
  input logic             susp,
  input logic [CNT_W-1:0] ecnt,
  input logic             ers_go,
  input logic             pgm_go,
  input logic             ers_all
);
  AST_PGM_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pgm_go |-> !ry_by); // R6
  AST_PGM_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) pgm_go |=> ry_by); // R6
  AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) (rd_start && !ry_by) |=> (tog != $past(tog))); // R7
  AST_ERASE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) ers_go |=> ry_by); // R10
  AST_SUSP_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (susp && $past(susp)) |-> $stable(ecnt)); // R12
  AST_SUSP_SECTOR_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(susp) |-> !ers_all); // R12
  AST_NO_ERASE_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n) ers_go |-> !susp); // R12
endmodule

bind fl_cmd_ctrl fl_cmd_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ry_by(ry_by), .rd_start(rd_start), .tog(tog),
  .susp(susp), .ecnt(ecnt), .ers_go(ers_go), .pgm_go(pgm_go), .ers_all(ers_all)
);

// File: tb/fl_cmd_ctrl_test.sv
module fl_cmd_ctrl_test;
  localparam int CLK_P = 10;
  localparam int PGM_C = 8;
  localparam int ERS_C = 40;
  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DEV = 16'h2291;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic ry_by;
  int n_chk = 0, n_bad = 0, lowcnt = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (!ry_by) lowcnt++;

  fl_cmd_ctrl #(.PGM_CYC(PGM_C), .ERS_CYC(ERS_C), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by(ry_by)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = rdata; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 400 && !ry_by; k++) @(negedge clk);
  endtask

  task automatic unlock_w(input logic [7:0] c);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, {8'h00, c});
  endtask

  task automatic prog_w(input logic [15:0] a, input logic [15:0] d);
    unlock_w(8'hA0); wr(a, d); wait_ready();
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", {15'd0, ry_by}, 16'h0001);
    chk("R1 idle rdata", rdata, 16'h0000);
  endtask

  task automatic t_chip_erase();
    logic [15:0] v;
    unlock_w(8'h80); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    lowcnt = 0; wr(16'h0555, 16'h0010); wait_ready();
    chk("R10 chip erase busy length", 16'(lowcnt), 16'(ERS_C));
    rd(16'h0000, v); chk("R10 word 0 erased", v, 16'hFFFF);
    rd(16'h001F, v); chk("R10 word 31 erased", v, 16'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] s1, s2, v;
    unlock_w(8'hA0);
    lowcnt = 0; wr(16'h0005, 16'h12F4);
    rd(16'h0005, s1); rd(16'h0005, s2);
    chk("R7 dq7 complement", {15'd0, s1[7]}, 16'h0000);
    chk("R7 dq6 toggles", {15'd0, s1[6] ^ s2[6]}, 16'h0001);
    wait_ready();
    chk("R6 program busy length", 16'(lowcnt), 16'(PGM_C));
    rd(16'h0005, v); chk("R6 programmed word", v, 16'h12F4);
  endtask

  task automatic t_fault();
    logic [15:0] v;
    prog_w(16'h0005, 16'h3A71);
    chk("R8 ready in fault", {15'd0, ry_by}, 16'h0001);
    rd(16'h0005, v); chk("R8 dq5 set", {15'd0, v[5]}, 16'h0001);
    wr(16'h0123, 16'h0000);
    rd(16'h0005, v); chk("R8 fault held by non-F0 write", {15'd0, v[5]}, 16'h0001);
    wr(16'h0777, 16'h00F0);
    rd(16'h0005, v); chk("R8 AND result after F0", v, 16'h1270);
  endtask

  task automatic t_high_bits();
    logic [15:0] v;
    wr(16'hF555, 16'h77AA); wr(16'h72AA, 16'hC355); wr(16'hA555, 16'h01A0);
    wr(16'h0009, 16'hBEEF); wait_ready();
    rd(16'h0009, v); chk("R3 R5 high bits ignored", v, 16'hBEEF);
  endtask

  task automatic t_malformed();
    logic [15:0] v;
    wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055); wr(16'h0555, 16'h00A0);
    wr(16'h0007, 16'h0000);
    chk("R4 no busy after bad sequence", {15'd0, ry_by}, 16'h0001);
    rd(16'h0007, v); chk("R4 word untouched", v, 16'hFFFF);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    unlock_w(8'hA0);
    @(negedge clk); addr = 16'h000A; wdata = 16'h5A5A; we_n = 1'b0;
    @(negedge clk); addr = 16'h000B; ce_n = 1'b0;
    @(negedge clk); addr = 16'h000C;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); wdata = 16'h0000; we_n = 1'b1;
    @(negedge clk); wait_ready();
    rd(16'h000B, v); chk("R2 later-fall address, first-rise data", v, 16'h5A5A);
    rd(16'h000A, v); chk("R2 earlier address unused", v, 16'hFFFF);
    rd(16'h000C, v); chk("R2 late address unused", v, 16'hFFFF);
  endtask

  task automatic t_ident();
    logic [15:0] v;
    unlock_w(8'h90);
    rd(16'h0000, v); chk("R9 maker code", v, MFR);
    rd(16'h0001, v); chk("R9 device code", v, DEV);
    rd(16'h0002, v); chk("R9 index 2", v, 16'h0000);
    wr(16'h0000, 16'h00F0);
    rd(16'h0005, v); chk("R9 exit to read", v, 16'h1270);
    byte_mode = 1'b1;
    wr(16'h0AAA, 16'h00AA); wr(16'h0555, 16'h0055); wr(16'h0AAA, 16'h0090);
    rd(16'h0000, v); chk("R9 byte maker code", v, {8'h00, MFR[7:0]});
    rd(16'h0002, v); chk("R9 byte device code", v, {8'h00, DEV[7:0]});
    wr(16'h0000, 16'h00F0);
    byte_mode = 1'b0;
  endtask

  task automatic t_byte();
    logic [15:0] v;
    byte_mode = 1'b1;
    wr(16'h5AAA, 16'h00AA); wr(16'h3555, 16'h0055); wr(16'h0AAA, 16'h00A0);
    wr(16'h000D, 16'h003C); wait_ready();
    rd(16'h000D, v); chk("R13 byte high lane", v, 16'h003C);
    rd(16'h000C, v); chk("R13 byte low lane kept", v, 16'h00FF);
    byte_mode = 1'b0;
    rd(16'h0006, v); chk("R13 word view", v, 16'h3CFF);
  endtask

  task automatic t_sector();
    logic [15:0] v;
    unlock_w(8'h80); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    lowcnt = 0; wr(16'h0008, 16'h0030); wait_ready();
    chk("R11 sector erase busy length", 16'(lowcnt), 16'(ERS_C));
    rd(16'h000B, v); chk("R11 sector 1 erased", v, 16'hFFFF);
    rd(16'h0009, v); chk("R11 sector 1 other word erased", v, 16'hFFFF);
    rd(16'h0005, v); chk("R11 sector 0 kept", v, 16'h1270);
  endtask

  task automatic t_suspend();
    logic [15:0] v;
    prog_w(16'h0011, 16'h00FF);
    unlock_w(8'h80); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    wr(16'h0010, 16'h0030);
    wr(16'h0000, 16'h00B0);
    chk("R12 ready while suspended", {15'd0, ry_by}, 16'h0001);
    rd(16'h0005, v); chk("R12 read other sector", v, 16'h1270);
    prog_w(16'h001A, 16'h4321);
    rd(16'h001A, v); chk("R12 program other sector", v, 16'h4321);
    unlock_w(8'hA0); wr(16'h0012, 16'h0000);
    chk("R12 program to suspended sector ignored", {15'd0, ry_by}, 16'h0001);
    rd(16'h0012, v); chk("R12 suspended sector untouched", v, 16'hFFFF);
    wr(16'h0000, 16'h0030);
    chk("R12 resumed busy", {15'd0, ry_by}, 16'h0000);
    wait_ready();
    rd(16'h0011, v); chk("R12 erase completed", v, 16'hFFFF);
    rd(16'h001A, v); chk("R12 other sector kept", v, 16'h4321);
    unlock_w(8'h80); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h0010); wr(16'h0000, 16'h00B0);
    chk("R12 chip erase ignores suspend", {15'd0, ry_by}, 16'h0000);
    wait_ready();
    rd(16'h0005, v); chk("R10 R12 chip erase finished", v, 16'hFFFF);
  endtask

  task automatic t_hw_abort();
    logic [15:0] v;
    unlock_w(8'hA0); wr(16'h0007, 16'h0000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset abort ready", {15'd0, ry_by}, 16'h0001);
    rd(16'h0007, v); chk("R1 aborted word kept", v, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_erase();
    t_program();
    t_fault();
    t_high_bits();
    t_malformed();
    t_latch();
    t_ident();
    t_byte();
    t_sector();
    t_suspend();
    t_hw_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule